// File: doc/BRIEF.md
# Scanline-Mirroring Left-Right Disparity Consistency Checker

This block sits behind two disparity engines of a stereo matcher. One engine produces disparities referenced to the right image, in normal pixel order. The other engine works on scanlines that were reversed before matching. Its left-referenced disparities therefore arrive with each line back to front. The block turns the left-referenced line back into normal order and delays the right-referenced line by one line period, so that both streams describe the same pixel in the same cycle. It then checks each right-referenced disparity against the left-referenced map and emits one checked disparity per pixel.

Both line buffers are ping-pong pairs of RAM banks. One bank takes the incoming line while the other bank plays back the previous line, and the banks swap at every start-of-line strobe, so the block accepts pixels without pause. The consistency test keeps a short history of the aligned left-referenced disparities. The current right-referenced disparity selects one entry of that history. If the selected entry equals the right-referenced value, that value passes through. If it does not, the newest left-referenced value is substituted.

Top module: `lrc_mirror_check`

## Requirements
- R1: While rst_ni is low, valid_o is 0 and disp_o is 0.
- R2: No output is valid until the second start-of-line strobe after reset. The first line after reset only fills a buffer.
- R3: An input pixel accepted at a rising edge (valid_i high) from the second line onward produces valid_o high exactly two rising edges later. Cycles with valid_i low produce no output cycle.
- R4: The left stream is reversed per line. The output at pixel position p of line k uses the disp_lm_i value that arrived at position LINE_LEN-1-p of line k.
- R5: The right stream is delayed by one line in order. The output at position p of line k uses the disp_r_i value from position p of line k, and every pixel of each line except the last one before reset is emitted once.
- R6: History taps count aligned output pixels. Tap 0 is the current aligned left value, and tap t is the aligned left value t valid pixels earlier, across line boundaries. Tap entries not yet written since reset read 0.
- R7: If the tap selected by the right value equals the right value, disp_o is the right value.
- R8: If the selected tap differs from the right value, disp_o is the current aligned left value (tap 0).
- R9: A right value of DEPTH or more selects tap DEPTH-1.
- R10: Idle cycles (valid_i low) leave the buffers, the history and disp_o unchanged.
- R11: Banks swap on every start-of-line strobe, so consecutive lines stream back to back without a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input pixel valid |
| sol_i | input | 1 | Start of line, high with the first pixel of each line |
| disp_r_i | input | DW | Right-referenced disparity, normal order |
| disp_lm_i | input | DW | Left-referenced disparity, line reversed |
| disp_o | output | DW | Checked disparity |
| valid_o | output | 1 | Output valid |

## Verification
The bench sends whole lines through the block and goes after the corners that change the result. These are the first line after reset, which must stay silent; a design that read the unwritten bank would emit junk early. Lines with idle gaps follow; a design that shifted its history on idle cycles would select the wrong tap from then on. Right values of DEPTH or more come next; a design that kept only the low select bits would match against a recent tap and pass a value that should have been replaced. The last case is a tap that reaches back into the previous line; a design that mirrored with the wrong address, or swapped banks at the wrong time, would pair pixels from different positions.

// File: rtl/lrc_pkg.sv
`timescale 1ns/1ps
package lrc_pkg;
  // saturate a tap request to the last history position
  function automatic int unsigned clamp_index(int unsigned value, int unsigned limit);
    return (value >= limit) ? limit - 1 : value;
  endfunction
endpackage

// File: rtl/lrc_line_ctrl.sv
`timescale 1ns/1ps
module lrc_line_ctrl #(
  parameter int unsigned LINE_LEN = 640,
  localparam int unsigned PW = (LINE_LEN > 1) ? $clog2(LINE_LEN) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          sol_i,
  output logic [PW-1:0] pos_o,
  output logic          bank_o,
  output logic          wr_en_o,
  output logic          rd_en_o
);
  logic [PW-1:0] cnt_q, pos_c;
  logic bank_q, bank_c, seen_q, armed_q, rd_ok_c;

  always_comb begin
    pos_c   = sol_i ? '0 : cnt_q;
    bank_c  = sol_i ? ~bank_q : bank_q;
    rd_ok_c = sol_i ? seen_q : armed_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      bank_q  <= 1'b0;
      seen_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (valid_i) begin
      cnt_q  <= (pos_c == PW'(LINE_LEN - 1)) ? '0 : pos_c + 1'b1;
      bank_q <= bank_c;
      if (sol_i) begin
        seen_q  <= 1'b1;
        armed_q <= seen_q;
      end
    end
  end

  assign pos_o   = pos_c;
  assign bank_o  = bank_c;
  assign wr_en_o = valid_i;
  assign rd_en_o = valid_i & rd_ok_c;

  // R11
  bank_swap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sol_i) |=> (bank_q != $past(bank_q)));
  // R2
  no_early_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |-> seen_q);
endmodule

// File: rtl/lrc_line_buf.sv
`timescale 1ns/1ps
module lrc_line_buf #(
  parameter int unsigned LINE_LEN = 640,
  parameter int unsigned DW       = 6,
  parameter bit          REVERSE  = 1'b1,
  localparam int unsigned PW = (LINE_LEN > 1) ? $clog2(LINE_LEN) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic          bank_i,
  input  logic [PW-1:0] pos_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          valid_o
);
  logic [DW-1:0] mem_q [2][LINE_LEN];
  logic [PW-1:0] rd_addr;
  logic [DW-1:0] data_q;
  logic          valid_q;

  generate
    if (REVERSE) begin : g_rev
      assign rd_addr = PW'(LINE_LEN - 1) - pos_i;
    end else begin : g_fwd
      assign rd_addr = pos_i;
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[bank_i][pos_i] <= data_i;
  end

  // read side always uses the bank not being written
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= rd_en_i;
      if (rd_en_i) data_q <= mem_q[~bank_i][rd_addr];
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;

  // R3
  rd_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> valid_o);
  // R10
  rd_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> (!valid_o && $stable(data_o)));
endmodule

// File: rtl/lrc_tap_check.sv
`timescale 1ns/1ps
module lrc_tap_check #(
  parameter int unsigned DW    = 6,
  parameter int unsigned DEPTH = 32,
  localparam int unsigned SW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [DW-1:0] left_i,
  input  logic [DW-1:0] right_i,
  output logic [DW-1:0] disp_o,
  output logic          valid_o
);
  localparam logic [DW:0] DEPTH_V = (DW + 1)'(DEPTH);

  logic [DW-1:0] hist_q [DEPTH-1];
  logic [DW-1:0] taps   [DEPTH];
  logic [SW-1:0] sel;
  logic [DW-1:0] picked;
  logic          agree;
  logic [DW-1:0] disp_q;
  logic          valid_q;

  assign taps[0] = left_i;
  generate
    for (genvar t = 1; t < DEPTH; t++) begin : g_tap
      assign taps[t] = hist_q[t-1];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH - 1; i++) hist_q[i] <= '0;
    end else if (valid_i) begin
      hist_q[0] <= left_i;
      for (int i = 1; i < DEPTH - 1; i++) hist_q[i] <= hist_q[i-1];
    end
  end

  always_comb begin
    sel    = SW'(lrc_pkg::clamp_index(32'(right_i), DEPTH));
    picked = taps[sel];
    agree  = (picked == right_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      disp_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) disp_q <= agree ? right_i : left_i;
    end
  end

  assign disp_o  = disp_q;
  assign valid_o = valid_q;

  // R7
  zero_disp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && right_i == '0) |=> (disp_o == $past(left_i)));
  // R8
  one_of_two_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (disp_o == $past(right_i) || disp_o == $past(left_i)));
  // R9
  clamp_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && {1'b0, right_i} >= DEPTH_V && right_i == hist_q[DEPTH-2])
      |=> (disp_o == $past(right_i)));
  // R9
  clamp_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && {1'b0, right_i} >= DEPTH_V && right_i != hist_q[DEPTH-2])
      |=> (disp_o == $past(left_i)));
  // R10
  hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(disp_o) && !valid_o));
endmodule

// File: rtl/lrc_mirror_check.sv
`timescale 1ns/1ps
module lrc_mirror_check #(
  parameter int unsigned LINE_LEN = 640,
  parameter int unsigned DW       = 6,
  parameter int unsigned DEPTH    = 32,
  localparam int unsigned PW = (LINE_LEN > 1) ? $clog2(LINE_LEN) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          sol_i,
  input  logic [DW-1:0] disp_r_i,
  input  logic [DW-1:0] disp_lm_i,
  output logic [DW-1:0] disp_o,
  output logic          valid_o
);
  logic [PW-1:0] pos;
  logic          bank, wr_en, rd_en;
  logic [DW-1:0] l_al, r_al;
  logic          l_v, r_v;

  lrc_line_ctrl #(.LINE_LEN(LINE_LEN)) u_ctrl (
    .clk_i, .rst_ni, .valid_i, .sol_i,
    .pos_o(pos), .bank_o(bank), .wr_en_o(wr_en), .rd_en_o(rd_en)
  );

  // left stream arrives reversed: play it back reversed again
  lrc_line_buf #(.LINE_LEN(LINE_LEN), .DW(DW), .REVERSE(1'b1)) u_lbuf (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .rd_en_i(rd_en), .bank_i(bank),
    .pos_i(pos), .data_i(disp_lm_i), .data_o(l_al), .valid_o(l_v)
  );

  // right stream gets the same one-line delay in order
  lrc_line_buf #(.LINE_LEN(LINE_LEN), .DW(DW), .REVERSE(1'b0)) u_rbuf (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .rd_en_i(rd_en), .bank_i(bank),
    .pos_i(pos), .data_i(disp_r_i), .data_o(r_al), .valid_o(r_v)
  );

  lrc_tap_check #(.DW(DW), .DEPTH(DEPTH)) u_chk (
    .clk_i, .rst_ni, .valid_i(l_v & r_v), .left_i(l_al), .right_i(r_al),
    .disp_o, .valid_o
  );

  // R3
  out_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en |=> ##1 valid_o);
endmodule

// File: tb/lrc_mirror_check_bench.sv
`timescale 1ns/1ps
module lrc_mirror_check_bench;
  localparam int N = 16, DW = 6, DEPTH = 32, NL = 7;
  // row: r_base, r_step, l_base, l_step, gap
  localparam logic [24:0] VEC [NL] = '{
    {6'd3,  6'd0, 6'd3,  6'd0, 1'b0},
    {6'd0,  6'd1, 6'd5,  6'd0, 1'b0},
    {6'd20, 6'd0, 6'd55, 6'd0, 1'b1},
    {6'd55, 6'd0, 6'd0,  6'd0, 1'b0},
    {6'd2,  6'd2, 6'd7,  6'd1, 1'b1},
    {6'd0,  6'd0, 6'd9,  6'd3, 1'b0},
    {6'd1,  6'd1, 6'd1,  6'd1, 1'b0}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, valid, sol;
  logic [DW-1:0] dr, dl, disp_o;
  logic valid_o;

  lrc_mirror_check #(.LINE_LEN(N), .DW(DW), .DEPTH(DEPTH)) u_lrc_mirror_check (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .sol_i(sol),
    .disp_r_i(dr), .disp_lm_i(dl), .disp_o(disp_o), .valid_o(valid_o)
  );

  int tests = 0, fails = 0;
  int exp_d [256];
  int exp_c [256];
  int exp_n = 0, mon_n = 0, sols = 0;
  bit mon_en = 0, done = 0;
  logic [1:0] pv;

  function automatic int rv(int row, int p);
    return (int'(VEC[row][24:19]) + int'(VEC[row][18:13]) * p) % 64;
  endfunction
  function automatic int lv(int row, int x);
    return (int'(VEC[row][12:7]) + int'(VEC[row][6:1]) * x) % 64;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic build(input int first, input int count);
    int hq [DEPTH];
    for (int i = 0; i < DEPTH; i++) hq[i] = 0;
    exp_n = 0;
    for (int k = first; k < first + count - 1; k++) begin
      for (int p = 0; p < N; p++) begin
        int r, l, s, t;
        r = rv(k, p);
        l = lv(k, p);
        s = (r >= DEPTH) ? DEPTH - 1 : r;
        t = (s == 0) ? l : hq[s-1];
        exp_d[exp_n] = (t == r) ? r : l;
        exp_c[exp_n] = (r >= DEPTH) ? 2 : ((t == r) ? 0 : 1);
        exp_n++;
        for (int i = DEPTH - 2; i > 0; i--) hq[i] = hq[i-1];
        hq[0] = l;
      end
    end
  endtask

  task automatic drive(input int first, input int count);
    for (int k = first; k < first + count; k++) begin
      for (int p = 0; p < N; p++) begin
        @(posedge clk); #2;
        valid = 1'b1;
        sol   = (p == 0);
        dr    = DW'(rv(k, p));
        dl    = DW'(lv(k, N - 1 - p));
        if (VEC[k][0] && (p % 3 == 2)) begin
          @(posedge clk); #2;
          valid = 1'b0;
          sol   = 1'b0;
        end
      end
    end
    @(posedge clk); #2;
    valid = 1'b0;
    sol   = 1'b0;
    repeat (4) @(posedge clk);
  endtask

  // bench-side model of when outputs must appear
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv   <= 2'b00;
      sols <= 0;
    end else begin
      pv <= {pv[0], valid && (sol ? (sols >= 1) : (sols >= 2))};
      if (valid && sol) sols <= sols + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && mon_en) begin
      chk(valid_o === pv[1], "R3 output timing", int'(valid_o), int'(pv[1]));
      if (sols < 2) chk(valid_o === 1'b0, "R2 first line silent", int'(valid_o), 0);
      if (valid_o === 1'b1) begin
        if (mon_n < exp_n) begin
          string tg;
          tg = (exp_c[mon_n] == 0) ? "R7 agree" : (exp_c[mon_n] == 1) ? "R8 fallback" : "R9 clamp";
          chk(int'(disp_o) == exp_d[mon_n],
              $sformatf("%s R4 R5 R6 R10 R11 pixel %0d", tg, mon_n), int'(disp_o), exp_d[mon_n]);
        end else begin
          chk(1'b0, "R5 extra output", mon_n, exp_n);
        end
        mon_n++;
      end
    end
  end

  initial begin
    #(20 * 50000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired R3 actual=%0d expected=%0d", mon_n, exp_n);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; valid = 1'b0; sol = 1'b0; dr = '0; dl = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(valid_o === 1'b0, "R1 reset valid", int'(valid_o), 0);
    chk(disp_o === '0, "R1 reset disp", int'(disp_o), 0);
    @(posedge clk); #2;
    rst_n = 1'b1;

    // table walk: all rows back to back
    build(0, NL);
    mon_n  = 0;
    mon_en = 1'b1;
    drive(0, NL);
    chk(mon_n == exp_n, "R5 output count", mon_n, exp_n);
    mon_en = 1'b0;

    // reset mid-line with a nonzero output held
    @(posedge clk); #2;
    valid = 1'b1; sol = 1'b1; dr = 6'd7; dl = 6'd9;
    @(posedge clk); #2;
    sol = 1'b0;
    @(posedge clk); #2;
    rst_n = 1'b0; valid = 1'b0;
    @(negedge clk);
    chk(valid_o === 1'b0, "R1 mid-run reset valid", int'(valid_o), 0);
    chk(disp_o === '0, "R1 mid-run reset disp", int'(disp_o), 0);
    @(posedge clk); #2;
    rst_n = 1'b1;

    // after reset: first line silent, history restarts at zero
    build(0, 3);
    mon_n  = 0;
    mon_en = 1'b1;
    drive(0, 3);
    chk(mon_n == exp_n, "R2 R5 output count after reset", mon_n, exp_n);
    mon_en = 1'b0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule